// File: doc/BRIEF.md
# Raster Frame Writeback Address Generator

This block produces the write addresses for storing a frame into a linear raster buffer in memory. Software, or a frame controller, supplies a base byte address, a line pitch in bytes, a packed dimension word and a pixel format class, then pulses `start`. If the settings pass their legality checks, the block walks the frame one line at a time. Each line begins at the base plus the line index times the pitch, and its pixels are packed contiguously into 32-bit words. For every word it presents an address, a byte count and byte-lane enables on a valid/ready port.

The memory side returns one in-order response for each accepted word. The block counts lines whose final word has been acknowledged and exposes that count as a progress value. When the count reaches the frame height it emits a one-cycle done pulse and leaves the busy state. A start request with illegal settings is refused: a one-cycle error pulse is raised and no frame begins.

Top module: `rwb_addr_gen`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `frame_done` and `cfg_err` are low and `progress` is 0. A `start` pulse with legal settings makes `busy` and `wr_valid` high in the next cycle, and the first word address equals the base.
- R2: Line n begins at base + n*pitch. Successive words of one line step by 4 bytes, lines are issued in order, and every address is a multiple of 4.
- R3: The format code selects the bytes per pixel: 0 gives 2, 1 gives 3, 2 gives 4. A line takes ceil(width*bpp/4) words. Every word carries a count of 4 except the last, which carries width*bpp mod 4 (4 when that is 0). `wr_ben` has its lowest `wr_cnt` bits set, with bit 0 the lowest byte address.
- R4: A base whose two low bits are not both zero is refused. `cfg_err` pulses for one cycle in the cycle after `start`, and no write is issued.
- R5: A pitch with any of its four low bits set is refused in the same way as R4.
- R6: The dimension word holds the height in bits 31:16 and the width in bits 15:0. A height above 4088, a height of 0 or a width of 0 is refused. A height of exactly 4088 is accepted.
- R7: Format code 1 (3 bytes per pixel) is refused when `cfg_rotate` or `cfg_tiled` is set. Format code 3 is always refused.
- R8: `progress` counts the lines whose last word has been acknowledged on `resp_valid`, one response per accepted word, in order. It returns to 0 when a frame is accepted. A refused start leaves it unchanged.
- R9: `frame_done` is a one-cycle pulse in the same cycle in which `progress` first equals the height, and `busy` falls in that same cycle.
- R10: `start` while `busy` is high is ignored. The current frame and its progress are unaffected and `cfg_err` stays low.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_cnt` and `wr_ben` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start request |
| cfg_base | input | ADDR_W | Destination byte address of line 0 |
| cfg_pitch | input | PITCH_W | Byte distance between line starts |
| cfg_dim | input | 2*DIM_W | Height (upper half) and width (lower half) |
| cfg_fmt | input | 2 | Pixel format class: 0=2 B, 1=3 B, 2=4 B, 3=illegal |
| cfg_rotate | input | 1 | Rotation requested (illegal with 3-byte pixels) |
| cfg_tiled | input | 1 | Tiled layout requested (illegal with 3-byte pixels) |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Write word accepted |
| wr_addr | output | ADDR_W | Byte address of the word, 4-byte aligned |
| wr_cnt | output | 3 | Valid bytes in the word (1..4) |
| wr_ben | output | 4 | Byte-lane enables |
| resp_valid | input | 1 | Write response for the oldest outstanding word |
| progress | output | DIM_W | Lines committed to memory |
| frame_done | output | 1 | One-cycle pulse at frame completion |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | One-cycle pulse when a start is refused |

## Verification
The issue side and the commit side run independently, so three things can land on the same edge: a handshake that opens a new line, the response that closes an earlier line, and a start request arriving on the edge of the frame's final response. The bench varies the ready and response rates so that handshakes and responses overlap across line boundaries. In one frame it raises `start` exactly on the cycle in which it returns the last response. A behavioural model updates its expected counters for both events on each edge and compares progress, done, busy and the error pulse every cycle. The early start must be ignored, because `busy` is still high at that edge.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

   typedef enum logic [1:0] {
      PX_16  = 2'd0,
      PX_24  = 2'd1,
      PX_32  = 2'd2,
      PX_BAD = 2'd3
   } px_fmt_e;

   function automatic logic [2:0] px_bytes(input px_fmt_e f);
      case (f)
         PX_16:   px_bytes = 3'd2;
         PX_24:   px_bytes = 3'd3;
         PX_32:   px_bytes = 3'd4;
         default: px_bytes = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/rwb_cfg_check.sv
module rwb_cfg_check
   import rwb_pkg::*;
#(
   parameter int DIM_W    = 16,
   parameter int MAX_H    = 4088,
   parameter int BASE_LSB = 2,
   parameter int PITCH_LSB = 4
) (
   input  logic [BASE_LSB-1:0]  base_lsb,
   input  logic [PITCH_LSB-1:0] pitch_lsb,
   input  logic [2*DIM_W-1:0]   dim,
   input  logic [1:0]           fmt,
   input  logic                 rotate,
   input  logic                 tiled,
   output logic                 ok,
   output logic [DIM_W-1:0]     height,
   output logic [DIM_W-1:0]     words,
   output logic [2:0]           last_cnt
);
   localparam int LB_W = DIM_W + 2;
   localparam logic [DIM_W-1:0] MAX_H_V = DIM_W'(MAX_H);

   px_fmt_e          f;
   logic [DIM_W-1:0] width;
   logic [LB_W-1:0]  line_bytes;
   logic [LB_W-1:0]  rounded;

   assign f          = px_fmt_e'(fmt);
   assign height     = dim[2*DIM_W-1:DIM_W];
   assign width      = dim[DIM_W-1:0];
   assign line_bytes = LB_W'(width) * LB_W'(px_bytes(f));
   assign rounded    = line_bytes + LB_W'(3);
   assign words      = rounded[LB_W-1:2];
   assign last_cnt   = (line_bytes[1:0] == 2'b00) ? 3'd4 : {1'b0, line_bytes[1:0]};

   always_comb begin
      ok = 1'b1;
      if (base_lsb != '0)                      ok = 1'b0;
      if (pitch_lsb != '0)                     ok = 1'b0;
      if (height == '0 || width == '0)         ok = 1'b0;
      if (height > MAX_H_V)                    ok = 1'b0;
      if (f == PX_BAD)                         ok = 1'b0;
      if (f == PX_24 && (rotate || tiled))     ok = 1'b0;
   end

endmodule

// File: rtl/rwb_addr_walk.sv
module rwb_addr_walk #(
   parameter int ADDR_W     = 32,
   parameter int PITCH_W    = 16,
   parameter int DIM_W      = 16,
   parameter bit HIGH_LANES = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [ADDR_W-1:0]  base,
   input  logic [PITCH_W-1:0] pitch,
   input  logic [DIM_W-1:0]   height,
   input  logic [DIM_W-1:0]   words,
   input  logic [2:0]         last_cnt,
   input  logic               wr_ready,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [2:0]         wr_cnt,
   output logic [3:0]         wr_ben
);
   logic               issuing;
   logic [DIM_W-1:0]   line_idx, word_idx, h_q, words_q;
   logic [2:0]         last_q;
   logic [PITCH_W-1:0] pitch_q;
   logic [ADDR_W-1:0]  line_addr;
   logic               end_of_line;

   assign end_of_line = (word_idx + 1'b1 == words_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issuing   <= 1'b0;
         line_idx  <= '0;
         word_idx  <= '0;
         line_addr <= '0;
         h_q       <= '0;
         words_q   <= '0;
         last_q    <= 3'd4;
         pitch_q   <= '0;
      end else if (go) begin
         issuing   <= 1'b1;
         line_idx  <= '0;
         word_idx  <= '0;
         line_addr <= base;
         h_q       <= height;
         words_q   <= words;
         last_q    <= last_cnt;
         pitch_q   <= pitch;
      end else if (issuing && wr_ready) begin
         if (end_of_line) begin
            word_idx  <= '0;
            line_idx  <= line_idx + 1'b1;
            line_addr <= line_addr + ADDR_W'(pitch_q);
            if (line_idx + 1'b1 == h_q) issuing <= 1'b0;
         end else begin
            word_idx <= word_idx + 1'b1;
         end
      end
   end

   assign wr_valid = issuing;
   assign wr_addr  = line_addr + (ADDR_W'(word_idx) << 2);
   assign wr_cnt   = end_of_line ? last_q : 3'd4;

   generate
      if (HIGH_LANES) begin : g_lanes_hi
         assign wr_ben = 4'hF << (3'd4 - wr_cnt);
      end else begin : g_lanes_lo
         assign wr_ben = 4'hF >> (3'd4 - wr_cnt);
      end
   endgenerate

   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_addr[1:0] == 2'b00);
   p_cnt_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_cnt != 3'd0 && wr_cnt <= 3'd4 && $countones(wr_ben) == int'(wr_cnt)));

endmodule

// File: rtl/rwb_commit_track.sv
module rwb_commit_track #(
   parameter int DIM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DIM_W-1:0] height,
   input  logic [DIM_W-1:0] words,
   input  logic             resp_valid,
   output logic [DIM_W-1:0] progress,
   output logic             frame_done,
   output logic             busy
);
   logic [DIM_W-1:0] rword, h_q, words_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rword      <= '0;
         progress   <= '0;
         frame_done <= 1'b0;
         busy       <= 1'b0;
         h_q        <= '0;
         words_q    <= '0;
      end else begin
         frame_done <= 1'b0;
         if (go) begin
            rword    <= '0;
            progress <= '0;
            busy     <= 1'b1;
            h_q      <= height;
            words_q  <= words;
         end else if (busy && resp_valid) begin
            if (rword + 1'b1 == words_q) begin
               rword    <= '0;
               progress <= progress + 1'b1;
               if (progress + 1'b1 == h_q) begin
                  frame_done <= 1'b1;
                  busy       <= 1'b0;
               end
            end else begin
               rword <= rword + 1'b1;
            end
         end
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   p_done_at_height_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (progress == h_q && !busy));
   p_prog_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> progress < h_q);

endmodule

// File: rtl/rwb_addr_gen.sv
module rwb_addr_gen
   import rwb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PITCH_W    = 16,
   parameter int DIM_W      = 16,
   parameter int MAX_H      = 4088,
   parameter int BASE_LSB   = 2,
   parameter int PITCH_LSB  = 4,
   parameter bit HIGH_LANES = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [PITCH_W-1:0] cfg_pitch,
   input  logic [2*DIM_W-1:0] cfg_dim,
   input  logic [1:0]         cfg_fmt,
   input  logic               cfg_rotate,
   input  logic               cfg_tiled,
   output logic               wr_valid,
   input  logic               wr_ready,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [2:0]         wr_cnt,
   output logic [3:0]         wr_ben,
   input  logic               resp_valid,
   output logic [DIM_W-1:0]   progress,
   output logic               frame_done,
   output logic               busy,
   output logic               cfg_err
);
   generate
      if (MAX_H >= (1 << DIM_W)) begin : g_bad_maxh
         $error("MAX_H does not fit in DIM_W bits");
      end
      if (BASE_LSB < 2 || BASE_LSB >= ADDR_W) begin : g_bad_base
         $error("BASE_LSB must keep word alignment and fit ADDR_W");
      end
      if (PITCH_LSB < BASE_LSB || PITCH_LSB >= PITCH_W) begin : g_bad_pitch
         $error("PITCH_LSB out of range");
      end
   endgenerate

   logic             cfg_ok, go;
   logic [DIM_W-1:0] c_height, c_words;
   logic [2:0]       c_last;

   rwb_cfg_check #(
      .DIM_W(DIM_W), .MAX_H(MAX_H), .BASE_LSB(BASE_LSB), .PITCH_LSB(PITCH_LSB)
   ) u_check (
      .base_lsb (cfg_base[BASE_LSB-1:0]),
      .pitch_lsb(cfg_pitch[PITCH_LSB-1:0]),
      .dim      (cfg_dim),
      .fmt      (cfg_fmt),
      .rotate   (cfg_rotate),
      .tiled    (cfg_tiled),
      .ok       (cfg_ok),
      .height   (c_height),
      .words    (c_words),
      .last_cnt (c_last)
   );

   assign go = start && !busy && cfg_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= start && !busy && !cfg_ok;
   end

   rwb_addr_walk #(
      .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W), .HIGH_LANES(HIGH_LANES)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go),
      .base(cfg_base), .pitch(cfg_pitch), .height(c_height),
      .words(c_words), .last_cnt(c_last),
      .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_cnt(wr_cnt), .wr_ben(wr_ben)
   );

   rwb_commit_track #(.DIM_W(DIM_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .go(go),
      .height(c_height), .words(c_words), .resp_valid(resp_valid),
      .progress(progress), .frame_done(frame_done), .busy(busy)
   );

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_cnt) && $stable(wr_ben)));
   p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!busy && !wr_valid));
   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !cfg_err);
   p_issue_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> busy);

endmodule

// File: tb/tb_rwb_addr_gen.sv
module tb_rwb_addr_gen;
   localparam int CLK_NS = 10;
   localparam int WD_LIMIT = 150000;

   logic        clk, rst_n, start, cfg_rotate, cfg_tiled;
   logic [31:0] cfg_base, cfg_dim;
   logic [15:0] cfg_pitch;
   logic [1:0]  cfg_fmt;
   logic        wr_valid, wr_ready, resp_valid, frame_done, busy, cfg_err;
   logic [31:0] wr_addr;
   logic [2:0]  wr_cnt;
   logic [3:0]  wr_ben;
   logic [15:0] progress;

   rwb_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
      .cfg_pitch(cfg_pitch), .cfg_dim(cfg_dim), .cfg_fmt(cfg_fmt),
      .cfg_rotate(cfg_rotate), .cfg_tiled(cfg_tiled), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_ben(wr_ben),
      .resp_valid(resp_valid), .progress(progress), .frame_done(frame_done),
      .busy(busy), .cfg_err(cfg_err)
   );

   initial clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   int     checks = 0, errors = 0, cycles = 0;
   string  cur_tag = "R1 reset";
   longint q_addr[$];
   int     q_cnt[$];
   bit     m_iss = 0, m_busy = 0, m_done = 0, m_err = 0;
   int     m_prog = 0, m_rcnt = 0, m_words = 1, m_h = 0, outst = 0;
   int     ready_pct = 100, resp_pct = 100;
   bit     pend_start = 0, arm_final = 0;

   task automatic chk(string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
      end
   endtask

   function automatic bit legal_cfg();
      int h = int'(cfg_dim[31:16]);
      int w = int'(cfg_dim[15:0]);
      if (cfg_base % 4 != 0) return 0;
      if (cfg_pitch % 16 != 0) return 0;
      if (h == 0 || w == 0 || h > 4088) return 0;
      if (cfg_fmt == 2'd3) return 0;
      if (cfg_fmt == 2'd1 && (cfg_rotate || cfg_tiled)) return 0;
      return 1;
   endfunction

   task automatic build_frame();
      int h = int'(cfg_dim[31:16]);
      int w = int'(cfg_dim[15:0]);
      int lb = w * (int'(cfg_fmt) + 2);
      int nw = (lb + 3) / 4;
      q_addr.delete();
      q_cnt.delete();
      for (int n = 0; n < h; n++)
         for (int k = 0; k < nw; k++) begin
            q_addr.push_back(longint'(cfg_base) + longint'(n) * cfg_pitch + 4 * k);
            q_cnt.push_back((k == nw - 1) ? lb - 4 * (nw - 1) : 4);
         end
      m_words = nw;
      m_h = h;
   endtask

   always @(posedge clk) cycles++;

   always @(negedge clk) begin
      if (rst_n) begin
         bit rdy, rsp, st, busy0;
         chk("R1 wr_valid", wr_valid, m_iss);
         if (m_iss && wr_valid) begin
            chk("R2 wr_addr", wr_addr, q_addr[0]);
            chk("R3 wr_cnt", wr_cnt, q_cnt[0]);
            chk("R3 wr_ben", wr_ben, (1 << q_cnt[0]) - 1);
         end
         chk("R8 progress", progress, m_prog);
         chk("R9 frame_done", frame_done, m_done);
         chk("R9 busy", busy, m_busy);
         chk("R4 cfg_err", cfg_err, m_err);

         rdy = ($urandom_range(99) < ready_pct);
         rsp = (outst > 0) && ($urandom_range(99) < resp_pct);
         st = pend_start;
         pend_start = 0;
         if (arm_final && rsp && outst == 1 && m_rcnt == m_words - 1 && m_prog == m_h - 1) begin
            st = 1;
            arm_final = 0;
         end
         wr_ready = rdy;
         resp_valid = rsp;
         start = st;

         busy0 = m_busy;
         m_done = 0;
         m_err = 0;
         if (m_iss && rdy) begin
            void'(q_addr.pop_front());
            void'(q_cnt.pop_front());
            outst++;
         end
         if (rsp) begin
            outst--;
            m_rcnt++;
            if (m_rcnt == m_words) begin
               m_rcnt = 0;
               m_prog++;
               if (m_prog == m_h) begin
                  m_done = 1;
                  m_busy = 0;
               end
            end
         end
         m_iss = (q_addr.size() > 0);
         if (st && !busy0) begin
            if (legal_cfg()) begin
               build_frame();
               m_busy = 1;
               m_prog = 0;
               m_rcnt = 0;
               m_iss = 1;
            end else begin
               m_err = 1;
            end
         end
      end
   end

   task automatic set_cfg(string tag, int base, int pitch, int w, int h, int fmt,
                          bit rot, bit til, int rp, int sp);
      cur_tag = tag;
      cfg_base = base;
      cfg_pitch = pitch[15:0];
      cfg_dim = {h[15:0], w[15:0]};
      cfg_fmt = fmt[1:0];
      cfg_rotate = rot;
      cfg_tiled = til;
      ready_pct = rp;
      resp_pct = sp;
   endtask

   task automatic wait_idle();
      repeat (2) @(posedge clk);
      while ((m_busy || m_iss) && cycles < WD_LIMIT) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   task automatic run(string tag, int base, int pitch, int w, int h, int fmt,
                      bit rot, bit til, int rp, int sp);
      @(posedge clk);
      set_cfg(tag, base, pitch, w, h, fmt, rot, til, rp, sp);
      pend_start = 1;
      wait_idle();
   endtask

   initial begin
      rst_n = 0;
      start = 0;
      wr_ready = 0;
      resp_valid = 0;
      set_cfg("R1 reset", 0, 0, 0, 0, 0, 0, 0, 100, 100);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset progress", progress, 0);
      chk("R1 reset wr_valid", wr_valid, 0);
      chk("R1 reset frame_done", frame_done, 0);
      rst_n = 1;

      run("R1 R2 R3 32bpp", 'h1000, 32, 3, 2, 2, 0, 0, 100, 100);
      run("R8 refused start keeps progress, R4 base", 'h1002, 32, 3, 2, 2, 0, 0, 100, 100);
      run("R5 pitch", 'h1000, 40, 3, 2, 2, 0, 0, 100, 100);
      run("R6 height 4089", 'h1000, 32, 3, 4089, 2, 0, 0, 100, 100);
      run("R6 width 0", 'h1000, 32, 0, 2, 2, 0, 0, 100, 100);
      run("R6 height 0", 'h1000, 32, 4, 0, 2, 0, 0, 100, 100);
      run("R7 24bpp rotate", 'h1000, 32, 3, 2, 1, 1, 0, 100, 100);
      run("R7 24bpp tiled", 'h1000, 32, 3, 2, 1, 0, 1, 100, 100);
      run("R7 fmt 3", 'h1000, 32, 3, 2, 3, 0, 0, 100, 100);
      run("R7 32bpp rotate ok", 'h1100, 64, 4, 2, 2, 1, 1, 80, 80);
      run("R3 24bpp", 'h2004, 16, 5, 3, 1, 0, 0, 60, 50);
      run("R3 R11 16bpp stalls", 'h300, 48, 3, 4, 0, 0, 0, 40, 70);
      run("R2 R11 wide pitch", 'h7FFF_0000, 1024, 7, 5, 1, 0, 0, 70, 30);

      @(posedge clk);
      set_cfg("R10 start while busy", 'h4000, 64, 8, 3, 2, 0, 0, 50, 50);
      pend_start = 1;
      repeat (6) @(posedge clk);
      set_cfg("R10 start while busy", 'h5002, 16, 2, 2, 2, 0, 0, 50, 50);
      pend_start = 1;
      repeat (4) @(posedge clk);
      set_cfg("R10 start while busy", 'h6000, 16, 2, 2, 2, 0, 0, 50, 50);
      pend_start = 1;
      wait_idle();

      @(posedge clk);
      set_cfg("R9 R10 start on final response", 'h800, 16, 2, 2, 2, 0, 0, 100, 40);
      arm_final = 1;
      pend_start = 1;
      wait_idle();
      chk("R9 R10 early start consumed", arm_final, 0);

      run("R6 height 4088 accepted", 'h2000_0000, 16, 1, 4088, 0, 0, 0, 100, 100);
      run("R8 restart clears progress", 'h40, 16, 2, 2, 0, 0, 0, 90, 90);

      if (cycles >= WD_LIMIT) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles expected below %0d", cycles, WD_LIMIT);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles >= WD_LIMIT + 1000);
      errors++;
      $display("FAIL watchdog hung run actual=%0d expected=%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule